// File: doc/BRIEF.md
# PCI Bus Reset Sequencer

This block brings up an attached PCI bus in a safe order, after power-on or whenever software asks for it. When a start request arrives, it drives the active-low bus reset low and holds it there for a minimum hold window. Only after that window does it touch the bus clock. It first presents the chosen clock-frequency code, and one cycle later it switches the clock output on. The bus reset then stays low for a further settling window, so the clock is stable before the reset is let go.

All waits are counted in system clock cycles. They are derived from parameters: the system clock rate in kHz and the two windows in microseconds. One down-counter serves both windows and is reloaded each time the sequence enters a timed phase.

The bus reset output is not tied to the block's own reset input. A system reset puts the bus into reset. After that, only a completed start sequence releases it. The bus reset has no timing relation to the bus clock, so it may change at any system clock edge.

Top module: `pci_bus_reset_seq`

## Requirements
- R1: While `rst` is high and in the first cycle after it falls, `pci_rst_n_o`, `clk_en_o` and `done_o` are 0 and `freq_sel_o` is all zeros.
- R2: A `start_req` sampled high at a clock edge drives `pci_rst_n_o` and `clk_en_o` to 0 from that edge on, whatever the sequence was doing.
- R3: After the edge that samples a start, `pci_rst_n_o`, `clk_en_o` and `freq_sel_o` stay unchanged for HOLD_CYC edges. HOLD_CYC is CLK_FREQ_KHZ*HOLD_US/1000, with a minimum of 1.
- R4: At the edge HOLD_CYC edges after the start, `freq_sel_o` takes the value of `freq_sel_in` sampled at that edge. `clk_en_o` goes to 1 exactly one edge later.
- R5: `freq_sel_o` never changes while `clk_en_o` is 1.
- R6: `pci_rst_n_o` goes to 1 exactly SETTLE_CYC+1 edges after `clk_en_o` rises, and `clk_en_o` stays 1 from then on until the next start. SETTLE_CYC is CLK_FREQ_KHZ*SETTLE_US/1000, with a minimum of 1.
- R7: `done_o` is 1 exactly when `pci_rst_n_o` is 1.
- R8: After a system reset, `pci_rst_n_o` stays 0 for as long as no start is requested. Once it is released, it stays 1 until the next start or system reset.
- R9: A start requested during the settling window turns `clk_en_o` off at the next edge and runs the full hold window again.
- R10: Changes of `freq_sel_in` at any edge other than the one named in R4 have no effect on `freq_sel_o`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high system reset |
| start_req | input | 1 | Request to run the bring-up sequence, sampled each edge |
| freq_sel_in | input | FSEL_W | Clock-frequency code to apply |
| pci_rst_n_o | output | 1 | Active-low PCI bus reset |
| clk_en_o | output | 1 | Enables the PCI clock output |
| freq_sel_o | output | FSEL_W | Frequency code presented to the clock generator |
| done_o | output | 1 | Bus is out of reset |

## Verification
The bench builds the block with CLK_FREQ_KHZ = 100, which scales the 1000 µs hold to 100 cycles and the 100 µs settling window to 10 cycles. With those values several complete bring-ups, restarts in the hold window, restarts in the settling window and restarts after release all fit within a few thousand cycles. FSEL_W = 2 lets every frequency code be applied, and lets the input be changed between latch points.

// File: rtl/pci_rst_seq_pkg.sv
package pci_rst_seq_pkg;

  typedef enum logic [2:0] {
    ST_IDLE = 3'd0,
    ST_HOLD = 3'd1,
    ST_CFG  = 3'd2,
    ST_EN   = 3'd3,
    ST_WAIT = 3'd4,
    ST_REL  = 3'd5
  } seq_state_e;

  // Microseconds to system clock cycles, never below one cycle.
  function automatic int unsigned us_to_cycles(input int unsigned khz,
                                               input int unsigned us);
    int unsigned c;
    c = (khz * us) / 1000;
    if (c < 1) c = 1;
    return c;
  endfunction

endpackage

// File: rtl/pci_rst_seq_timer.sv
module pci_rst_seq_timer #(
  parameter int CNT_W = 8
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             load,
  input  logic [CNT_W-1:0] load_val,
  output logic             expired
);

  logic [CNT_W-1:0] cnt_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt_q <= '0;
    end else if (load) begin
      cnt_q <= load_val;
    end else if (cnt_q != '0) begin
      cnt_q <= cnt_q - 1'b1;
    end
  end

  assign expired = (cnt_q == '0);

endmodule

// File: rtl/pci_rst_seq_fsm.sv
module pci_rst_seq_fsm
  import pci_rst_seq_pkg::*;
#(
  parameter int CNT_W      = 8,
  parameter int HOLD_CYC   = 100,
  parameter int SETTLE_CYC = 10
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             start_req,
  input  logic             expired,
  output seq_state_e       state_q,
  output seq_state_e       state_d,
  output logic             tmr_load,
  output logic [CNT_W-1:0] tmr_val
);

  localparam logic [CNT_W-1:0] HOLD_LD   = CNT_W'(HOLD_CYC - 1);
  localparam logic [CNT_W-1:0] SETTLE_LD = CNT_W'(SETTLE_CYC - 1);

  always_comb begin
    state_d  = state_q;
    tmr_load = 1'b0;
    tmr_val  = '0;
    if (start_req) begin
      state_d  = ST_HOLD;
      tmr_load = 1'b1;
      tmr_val  = HOLD_LD;
    end else begin
      unique case (state_q)
        ST_IDLE: state_d = ST_IDLE;
        ST_HOLD: if (expired) state_d = ST_CFG;
        ST_CFG:  state_d = ST_EN;
        ST_EN: begin
          state_d  = ST_WAIT;
          tmr_load = 1'b1;
          tmr_val  = SETTLE_LD;
        end
        ST_WAIT: if (expired) state_d = ST_REL;
        ST_REL:  state_d = ST_REL;
        default: state_d = ST_IDLE;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (rst) state_q <= ST_IDLE;
    else     state_q <= state_d;
  end

endmodule

// File: rtl/pci_rst_seq_outregs.sv
module pci_rst_seq_outregs
  import pci_rst_seq_pkg::*;
#(
  parameter int FSEL_W = 2
) (
  input  logic              clk,
  input  logic              rst,
  input  seq_state_e        state_d,
  input  logic [FSEL_W-1:0] freq_sel_in,
  output logic              pci_rst_n_o,
  output logic              clk_en_o,
  output logic [FSEL_W-1:0] freq_sel_o,
  output logic              done_o
);

  always_ff @(posedge clk) begin
    if (rst) begin
      pci_rst_n_o <= 1'b0;
      clk_en_o    <= 1'b0;
      freq_sel_o  <= '0;
      done_o      <= 1'b0;
    end else begin
      pci_rst_n_o <= (state_d == ST_REL);
      done_o      <= (state_d == ST_REL);
      clk_en_o    <= (state_d == ST_EN) || (state_d == ST_WAIT) ||
                     (state_d == ST_REL);
      if (state_d == ST_CFG) freq_sel_o <= freq_sel_in;
    end
  end

endmodule

// File: rtl/pci_bus_reset_seq.sv
module pci_bus_reset_seq
  import pci_rst_seq_pkg::*;
#(
  parameter int CLK_FREQ_KHZ = 100_000,
  parameter int HOLD_US      = 1000,
  parameter int SETTLE_US    = 100,
  parameter int FSEL_W       = 2
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              start_req,
  input  logic [FSEL_W-1:0] freq_sel_in,
  output logic              pci_rst_n_o,
  output logic              clk_en_o,
  output logic [FSEL_W-1:0] freq_sel_o,
  output logic              done_o
);

  localparam int HOLD_CYC   = int'(us_to_cycles(CLK_FREQ_KHZ, HOLD_US));
  localparam int SETTLE_CYC = int'(us_to_cycles(CLK_FREQ_KHZ, SETTLE_US));
  localparam int MAX_CYC    = (HOLD_CYC > SETTLE_CYC) ? HOLD_CYC : SETTLE_CYC;
  localparam int CNT_W      = $clog2(MAX_CYC + 1);

  seq_state_e       state_q, state_d;
  logic             tmr_load, expired;
  logic [CNT_W-1:0] tmr_val;

  pci_rst_seq_timer #(.CNT_W(CNT_W)) u_timer (
    .clk      (clk),
    .rst      (rst),
    .load     (tmr_load),
    .load_val (tmr_val),
    .expired  (expired)
  );

  pci_rst_seq_fsm #(
    .CNT_W      (CNT_W),
    .HOLD_CYC   (HOLD_CYC),
    .SETTLE_CYC (SETTLE_CYC)
  ) u_fsm (
    .clk       (clk),
    .rst       (rst),
    .start_req (start_req),
    .expired   (expired),
    .state_q   (state_q),
    .state_d   (state_d),
    .tmr_load  (tmr_load),
    .tmr_val   (tmr_val)
  );

  pci_rst_seq_outregs #(.FSEL_W(FSEL_W)) u_out (
    .clk         (clk),
    .rst         (rst),
    .state_d     (state_d),
    .freq_sel_in (freq_sel_in),
    .pci_rst_n_o (pci_rst_n_o),
    .clk_en_o    (clk_en_o),
    .freq_sel_o  (freq_sel_o),
    .done_o      (done_o)
  );

endmodule

// File: rtl/pci_bus_reset_seq_chk.sv
module pci_bus_reset_seq_chk #(
  parameter int HOLD_CYC   = 100,
  parameter int SETTLE_CYC = 10,
  parameter int FSEL_W     = 2
) (
  input logic              clk,
  input logic              rst,
  input logic              start_req,
  input logic              pci_rst_n_o,
  input logic              clk_en_o,
  input logic [FSEL_W-1:0] freq_sel_o,
  input logic              done_o
);

  logic [31:0] hold_cnt, en_cnt;

  always_ff @(posedge clk) begin
    if (rst || start_req) hold_cnt <= '0;
    else if (!clk_en_o && !pci_rst_n_o && hold_cnt != 32'hFFFF_FFFF)
      hold_cnt <= hold_cnt + 1;
    if (rst || !clk_en_o) en_cnt <= '0;
    else if (en_cnt != 32'hFFFF_FFFF) en_cnt <= en_cnt + 1;
  end

  // R2
  start_forces_reset_chk: assert property (@(posedge clk) disable iff (rst)
    start_req |=> (!pci_rst_n_o && !clk_en_o));

  // R3
  hold_before_clock_chk: assert property (@(posedge clk) disable iff (rst)
    $rose(clk_en_o) |-> (hold_cnt >= HOLD_CYC));

  // R5
  fsel_frozen_chk: assert property (@(posedge clk) disable iff (rst)
    (clk_en_o && $past(clk_en_o)) |-> $stable(freq_sel_o));

  // R6
  settle_before_release_chk: assert property (@(posedge clk) disable iff (rst)
    $rose(pci_rst_n_o) |-> (clk_en_o && en_cnt >= SETTLE_CYC));

  // R7
  done_matches_release_chk: assert property (@(posedge clk) disable iff (rst)
    done_o == pci_rst_n_o);

endmodule

bind pci_bus_reset_seq pci_bus_reset_seq_chk #(
  .HOLD_CYC   (HOLD_CYC),
  .SETTLE_CYC (SETTLE_CYC),
  .FSEL_W     (FSEL_W)
) u_chk (
  .clk         (clk),
  .rst         (rst),
  .start_req   (start_req),
  .pci_rst_n_o (pci_rst_n_o),
  .clk_en_o    (clk_en_o),
  .freq_sel_o  (freq_sel_o),
  .done_o      (done_o)
);

// File: tb/pci_bus_reset_seq_bench.sv
module pci_bus_reset_seq_bench;

  localparam int KHZ    = 100;
  localparam int FSEL_W = 2;
  localparam int H      = 100;   // 100 kHz * 1000 us / 1000
  localparam int S      = 10;    // 100 kHz * 100 us / 1000

  logic              clk = 1'b0;
  logic              rst = 1'b1;
  logic              start_req = 1'b0;
  logic [FSEL_W-1:0] freq_sel_in = '0;
  logic              pci_rst_n_o, clk_en_o, done_o;
  logic [FSEL_W-1:0] freq_sel_o;

  int checks = 0;
  int errors = 0;
  int cyc = 0;
  bit finished = 0;

  always #5 clk = ~clk;

  pci_bus_reset_seq #(
    .CLK_FREQ_KHZ (KHZ),
    .HOLD_US      (1000),
    .SETTLE_US    (100),
    .FSEL_W       (FSEL_W)
  ) u_pci_bus_reset_seq (
    .clk         (clk),
    .rst         (rst),
    .start_req   (start_req),
    .freq_sel_in (freq_sel_in),
    .pci_rst_n_o (pci_rst_n_o),
    .clk_en_o    (clk_en_o),
    .freq_sel_o  (freq_sel_o),
    .done_o      (done_o)
  );

  // Reference model: edges elapsed since the last sampled start.
  int                t = -1;
  logic [FSEL_W-1:0] fsel_exp = '0;
  bit                was_rst = 1'b1;

  always @(posedge clk) begin
    was_rst = rst;
    if (rst) begin
      t = -1;
      fsel_exp = '0;
    end else if (start_req) begin
      t = 0;
    end else if (t >= 0 && t < 1000000) begin
      t = t + 1;
      if (t == H) fsel_exp = freq_sel_in;
    end
  end

  task automatic check(input string req, input string what,
                       input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s %s actual=%0d expected=%0d at cycle %0d",
               req, what, act, exp, cyc);
    end
  endtask

  // Compare against the model every cycle, away from the active edge.
  always @(negedge clk) begin
    bit rn, en;
    cyc++;
    rn = (t >= H + 2 + S);
    en = (t >= H + 1);
    if (was_rst) begin
      check("R1", "pci_rst_n", int'(pci_rst_n_o), 0);
      check("R1", "clk_en", int'(clk_en_o), 0);
    end else begin
      check("R3 R6 R8", "pci_rst_n", int'(pci_rst_n_o), int'(rn));
      check("R2 R4 R9", "clk_en", int'(clk_en_o), int'(en));
    end
    check("R4 R5 R10", "freq_sel", int'(freq_sel_o), int'(fsel_exp));
    check("R7", "done", int'(done_o), int'(rn));
  end

  task automatic finish_run();
    if (!finished) begin
      finished = 1;
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  endtask

  always @(posedge clk) begin
    if (cyc > 100000) begin
      checks++;
      errors++;
      $display("FAIL watchdog expired");
      finish_run();
    end
  end

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  task automatic pulse_start(input logic [FSEL_W-1:0] f);
    @(negedge clk);
    start_req = 1'b1;
    freq_sel_in = f;
    @(negedge clk);
    start_req = 1'b0;
  endtask

  initial begin
    idle(3);
    // R1: outputs while in reset
    check("R1", "freq_sel reset", int'(freq_sel_o), 0);
    check("R1", "done reset", int'(done_o), 0);
    rst = 1'b0;
    // R8: no release without a start
    idle(60);
    check("R8", "held without start", int'(pci_rst_n_o), 0);

    // Full bring-up with code 2; R10 input wiggle during hold
    pulse_start(2'd2);
    idle(20);
    freq_sel_in = 2'd3;
    idle(20);
    freq_sel_in = 2'd2;
    idle(H + S + 10);
    check("R6", "released", int'(pci_rst_n_o), 1);
    check("R4", "code applied", int'(freq_sel_o), 2);

    // R10: changing input after release leaves the output alone
    freq_sel_in = 2'd1;
    idle(15);
    check("R10", "code unchanged", int'(freq_sel_o), 2);
    check("R8", "stays released", int'(pci_rst_n_o), 1);

    // R9: restart in settling window
    pulse_start(2'd1);
    idle(H + 3);
    check("R4", "clock on", int'(clk_en_o), 1);
    pulse_start(2'd3);
    check("R9", "clock off after restart", int'(clk_en_o), 0);
    check("R9", "code kept", int'(freq_sel_o), 1);
    idle(H + S + 10);
    check("R9", "code after rerun", int'(freq_sel_o), 3);

    // R2: restart mid-hold, then restart after release
    pulse_start(2'd0);
    idle(40);
    pulse_start(2'd1);
    idle(H + S + 10);
    pulse_start(2'd2);
    check("R2", "reset after start", int'(pci_rst_n_o), 0);
    idle(H + S + 10);

    // R1: system reset while released
    rst = 1'b1;
    idle(3);
    rst = 1'b0;
    idle(10);
    check("R1", "code cleared", int'(freq_sel_o), 0);
    finish_run();
  end

endmodule